// File: doc/BRIEF.md
# Logical-Timestamp Lease Coherence Manager

This block keeps a small multicore system (default four cores, 32 lines) coherent. It orders every access by logical time and keeps no record of which cores hold a line. Each core has a logical clock. Each line carries a write timestamp, a read-lease timestamp and an optional owner index, so the per-line state grows with the logarithm of the core count.

A read or a lease renewal grants the requester a lease that ends at a logical time. The requester's copy stays usable while its clock is not past that lease. A write moves the writer's clock one past the current lease and makes the writer the owner. Cores holding older leases keep their copies, and no invalidation is sent to them. A request from another core that touches an owned line first flushes the owner's state to shared storage, which clears the owner. The request is then served.

Requests from all cores compete for one valid/ready channel under round-robin arbitration, and one is accepted per cycle. A registered response carries the data, the line's write timestamp, the granted lease and the requester's new clock. A per-core comparator reports whether a presented lease is still valid against that core's clock.

Top module: `lts_coherence_mgr`

## Requirements
- R1: After reset, every core clock and every line timestamp is zero, no line has an owner, `rsp_valid` and `ts_overflow` are low, and `chk_ok` is high for a presented lease of zero.
- R2: A read (op code 2'b00) from core c on line L sets the new clock p = max(clock_c, wts_L) and grants lease = max(rts_L, p) + LEASE. The lease is stored as rts_L. The response appears in the cycle after acceptance and carries L's data, the old wts_L, the lease and p.
- R3: A write (op code 2'b10) sets p = max(clock_c, rts_L + 1). It stores p as both wts_L and rts_L, stores the write data and makes c the owner. The response carries the written data, and its wts, lease and clock fields all equal p.
- R4: A request changes only the requesting core's clock. A core's clock never decreases, and no other core's state is touched when ownership moves.
- R5: `chk_ok[c]` is high exactly when core c's clock is less than or equal to the lease presented on `chk_lease` for core c. The comparison is combinational.
- R6: A non-writeback request that wins arbitration on a line owned by a different core is held off: `req_ready` stays low for exactly one cycle while the owner is cleared. The request is accepted in the next cycle.
- R7: A writeback (op code 2'b11) from the owner clears ownership without changing the timestamps or the clock. A writeback from a non-owner changes nothing. In both cases the response reports the line's current data, wts, rts and the unchanged clock.
- R8: At most one `req_ready` bit is high, and only for a valid request. The grant goes to the first valid core at or after the core that follows the last accepted one. `rsp_valid` is high exactly in the cycle after an acceptance.
- R9: When a new clock or lease would exceed the largest TS_W-bit value, it saturates at that value and `ts_overflow` is set and stays set until reset.
- R10: A lease renewal (op code 2'b01) follows the same timestamp rules and flush hold-off as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_CORES | Per-core request valid |
| req_ready | output | NUM_CORES | Per-core request accepted this cycle |
| req_op | input | 2*NUM_CORES | Per-core op code: 00 read, 01 renew, 10 write, 11 writeback |
| req_line | input | LINE_W*NUM_CORES | Per-core line index |
| req_wdata | input | DATA_W*NUM_CORES | Per-core write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_core | output | CORE_W | Core the response belongs to |
| rsp_op | output | 2 | Op code being answered |
| rsp_data | output | DATA_W | Line data |
| rsp_wts | output | TS_W | Line write timestamp |
| rsp_lease | output | TS_W | Granted lease (read-lease timestamp) |
| rsp_pts | output | TS_W | Requester's clock after the request |
| core_pts | output | TS_W*NUM_CORES | All core clocks |
| chk_lease | input | TS_W*NUM_CORES | Per-core lease to test |
| chk_ok | output | NUM_CORES | Presented lease still valid for that core |
| ts_overflow | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with four cores, eight lines, 16-bit data, 8-bit timestamps and a lease step of 40. With these values, a short run of alternating writes and reads drives a core clock and a lease past 255, which exercises saturation and the sticky flag. The reduced line count lets one four-core burst cover every arbitration rotation. The wide lease step makes expired and live leases easy to separate against the clock comparator.

// File: rtl/lts_pkg.sv
package lts_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_RENEW  = 2'b01,
    OP_WRITE  = 2'b10,
    OP_WRBACK = 2'b11
  } lts_op_e;
endpackage

// File: rtl/lts_rr_arbiter.sv
module lts_rr_arbiter #(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic               advance,
  output logic [IDX_W-1:0]   win_idx,
  output logic               win_vld
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  int cand;

  // search from the pointer; the lowest distance wins (last assignment)
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    cand    = 0;
    for (int k = NUM_REQ - 1; k >= 0; k--) begin
      cand = int'(ptr_q) + k;
      if (cand >= NUM_REQ) cand = cand - NUM_REQ;
      if (req[cand]) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (advance) begin
      if (win_idx == IDX_W'(NUM_REQ - 1)) ptr_d = '0;
      else                                ptr_d = win_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/lts_ts_calc.sv
module lts_ts_calc
  import lts_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int LEASE = 10
) (
  input  lts_op_e         op,
  input  logic [TS_W-1:0] core_pts,
  input  logic [TS_W-1:0] line_wts,
  input  logic [TS_W-1:0] line_rts,
  output logic [TS_W-1:0] nxt_pts,
  output logic [TS_W-1:0] nxt_wts,
  output logic [TS_W-1:0] nxt_rts,
  output logic [TS_W-1:0] lease_out,
  output logic            ovf
);
  localparam logic [TS_W:0] TS_MAX  = {1'b0, {TS_W{1'b1}}};
  localparam logic [TS_W:0] LEASE_X = (TS_W + 1)'(LEASE);

  logic [TS_W:0] pts_x, wts_x, rts_x;
  logic [TS_W:0] rd_pts, rd_base, rd_lease, wr_bump, wr_pts;

  function automatic logic [TS_W-1:0] sat(input logic [TS_W:0] v);
    return (v > TS_MAX) ? TS_MAX[TS_W-1:0] : v[TS_W-1:0];
  endfunction

  always_comb begin
    pts_x    = {1'b0, core_pts};
    wts_x    = {1'b0, line_wts};
    rts_x    = {1'b0, line_rts};
    rd_pts   = (pts_x > wts_x) ? pts_x : wts_x;
    rd_base  = (rts_x > rd_pts) ? rts_x : rd_pts;
    rd_lease = rd_base + LEASE_X;
    wr_bump  = rts_x + 1'b1;
    wr_pts   = (pts_x > wr_bump) ? pts_x : wr_bump;

    nxt_pts   = core_pts;
    nxt_wts   = line_wts;
    nxt_rts   = line_rts;
    lease_out = line_rts;
    ovf       = 1'b0;
    case (op)
      OP_READ, OP_RENEW: begin
        nxt_pts   = rd_pts[TS_W-1:0];
        nxt_rts   = sat(rd_lease);
        lease_out = sat(rd_lease);
        ovf       = (rd_lease > TS_MAX);
      end
      OP_WRITE: begin
        nxt_pts   = sat(wr_pts);
        nxt_wts   = sat(wr_pts);
        nxt_rts   = sat(wr_pts);
        lease_out = sat(wr_pts);
        ovf       = (wr_pts > TS_MAX);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lts_line_store.sv
module lts_line_store #(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int TS_W      = 16,
  parameter int CORE_W    = 2,
  parameter int LINE_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] idx,
  input  logic              upd_ts,
  input  logic              upd_data,
  input  logic              own_set,
  input  logic              own_clr,
  input  logic [CORE_W-1:0] new_owner,
  input  logic [TS_W-1:0]   new_wts,
  input  logic [TS_W-1:0]   new_rts,
  input  logic [DATA_W-1:0] new_data,
  output logic [TS_W-1:0]   rd_wts,
  output logic [TS_W-1:0]   rd_rts,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_own_vld,
  output logic [CORE_W-1:0] rd_owner
);
  logic [TS_W-1:0]   wts_q   [NUM_LINES];
  logic [TS_W-1:0]   rts_q   [NUM_LINES];
  logic [DATA_W-1:0] data_q  [NUM_LINES];
  logic              ownv_q  [NUM_LINES];
  logic [CORE_W-1:0] owner_q [NUM_LINES];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic hit;
    logic ownv_d;
    assign hit = (idx == LINE_W'(l));

    always_comb begin
      ownv_d = ownv_q[l];
      if (hit && own_set)      ownv_d = 1'b1;
      else if (hit && own_clr) ownv_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wts_q[l]   <= '0;
        rts_q[l]   <= '0;
        data_q[l]  <= '0;
        ownv_q[l]  <= 1'b0;
        owner_q[l] <= '0;
      end else begin
        if (hit && upd_ts) begin
          wts_q[l] <= new_wts;
          rts_q[l] <= new_rts;
        end
        if (hit && upd_data) data_q[l]  <= new_data;
        if (hit && own_set)  owner_q[l] <= new_owner;
        ownv_q[l] <= ownv_d;
      end
    end
  end

  assign rd_wts     = wts_q[idx];
  assign rd_rts     = rts_q[idx];
  assign rd_data    = data_q[idx];
  assign rd_own_vld = ownv_q[idx];
  assign rd_owner   = owner_q[idx];
endmodule

// File: rtl/lts_coherence_mgr.sv
module lts_coherence_mgr
  import lts_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int TS_W      = 16,
  parameter int LEASE     = 10,
  parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        req_valid,
  output logic [NUM_CORES-1:0]        req_ready,
  input  logic [2*NUM_CORES-1:0]      req_op,
  input  logic [LINE_W*NUM_CORES-1:0] req_line,
  input  logic [DATA_W*NUM_CORES-1:0] req_wdata,
  output logic                        rsp_valid,
  output logic [CORE_W-1:0]           rsp_core,
  output logic [1:0]                  rsp_op,
  output logic [DATA_W-1:0]           rsp_data,
  output logic [TS_W-1:0]             rsp_wts,
  output logic [TS_W-1:0]             rsp_lease,
  output logic [TS_W-1:0]             rsp_pts,
  output logic [TS_W*NUM_CORES-1:0]   core_pts,
  input  logic [TS_W*NUM_CORES-1:0]   chk_lease,
  output logic [NUM_CORES-1:0]        chk_ok,
  output logic                        ts_overflow
);
  lts_op_e           op_c    [NUM_CORES];
  logic [LINE_W-1:0] line_c  [NUM_CORES];
  logic [DATA_W-1:0] wdata_c [NUM_CORES];
  logic [TS_W-1:0]   pts_q   [NUM_CORES];

  logic [CORE_W-1:0] win_idx;
  logic              win_vld, need_flush, accept, own_clr;
  lts_op_e           sel_op;
  logic [LINE_W-1:0] sel_line;
  logic [DATA_W-1:0] sel_wdata;
  logic [TS_W-1:0]   sel_pts;
  logic [TS_W-1:0]   ln_wts, ln_rts, nxt_pts, nxt_wts, nxt_rts, lease_val;
  logic [DATA_W-1:0] ln_data;
  logic              ln_own_vld, calc_ovf;
  logic [CORE_W-1:0] ln_owner;

  logic              rsp_valid_q, rsp_valid_d, ovf_q, ovf_d;
  logic [CORE_W-1:0] rsp_core_q;
  logic [1:0]        rsp_op_q;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic [TS_W-1:0]   rsp_wts_q, rsp_lease_q, rsp_pts_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [TS_W-1:0] pts_d;
    assign op_c[c]    = lts_op_e'(req_op[2*c +: 2]);
    assign line_c[c]  = req_line[LINE_W*c +: LINE_W];
    assign wdata_c[c] = req_wdata[DATA_W*c +: DATA_W];
    assign req_ready[c] = accept && (win_idx == CORE_W'(c));
    assign chk_ok[c]    = (pts_q[c] <= chk_lease[TS_W*c +: TS_W]);
    assign core_pts[TS_W*c +: TS_W] = pts_q[c];

    always_comb begin
      pts_d = pts_q[c];
      if (accept && (win_idx == CORE_W'(c))) pts_d = nxt_pts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pts_q[c] <= '0;
      else        pts_q[c] <= pts_d;
    end
  end

  lts_rr_arbiter #(.NUM_REQ(NUM_CORES), .IDX_W(CORE_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_valid),
    .advance (accept),
    .win_idx (win_idx),
    .win_vld (win_vld)
  );

  assign sel_op    = op_c[win_idx];
  assign sel_line  = line_c[win_idx];
  assign sel_wdata = wdata_c[win_idx];
  assign sel_pts   = pts_q[win_idx];

  // an owned line is flushed before anyone else may touch it
  assign need_flush = win_vld && ln_own_vld && (ln_owner != win_idx) && (sel_op != OP_WRBACK);
  assign accept     = win_vld && !need_flush;
  assign own_clr    = need_flush ||
                      (accept && (sel_op == OP_WRBACK) && ln_own_vld && (ln_owner == win_idx));

  lts_line_store #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .TS_W      (TS_W),
    .CORE_W    (CORE_W),
    .LINE_W    (LINE_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (sel_line),
    .upd_ts     (accept),
    .upd_data   (accept && (sel_op == OP_WRITE)),
    .own_set    (accept && (sel_op == OP_WRITE)),
    .own_clr    (own_clr),
    .new_owner  (win_idx),
    .new_wts    (nxt_wts),
    .new_rts    (nxt_rts),
    .new_data   (sel_wdata),
    .rd_wts     (ln_wts),
    .rd_rts     (ln_rts),
    .rd_data    (ln_data),
    .rd_own_vld (ln_own_vld),
    .rd_owner   (ln_owner)
  );

  lts_ts_calc #(.TS_W(TS_W), .LEASE(LEASE)) u_calc (
    .op        (sel_op),
    .core_pts  (sel_pts),
    .line_wts  (ln_wts),
    .line_rts  (ln_rts),
    .nxt_pts   (nxt_pts),
    .nxt_wts   (nxt_wts),
    .nxt_rts   (nxt_rts),
    .lease_out (lease_val),
    .ovf       (calc_ovf)
  );

  always_comb begin
    rsp_valid_d = accept;
    rsp_data_d  = (sel_op == OP_WRITE) ? sel_wdata : ln_data;
    ovf_d       = ovf_q | (accept & calc_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_core_q  <= '0;
      rsp_op_q    <= '0;
      rsp_data_q  <= '0;
      rsp_wts_q   <= '0;
      rsp_lease_q <= '0;
      rsp_pts_q   <= '0;
      ovf_q       <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      ovf_q       <= ovf_d;
      if (accept) begin
        rsp_core_q  <= win_idx;
        rsp_op_q    <= sel_op;
        rsp_data_q  <= rsp_data_d;
        rsp_wts_q   <= (sel_op == OP_WRITE) ? nxt_wts : ln_wts;
        rsp_lease_q <= lease_val;
        rsp_pts_q   <= nxt_pts;
      end
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_core    = rsp_core_q;
  assign rsp_op      = rsp_op_q;
  assign rsp_data    = rsp_data_q;
  assign rsp_wts     = rsp_wts_q;
  assign rsp_lease   = rsp_lease_q;
  assign rsp_pts     = rsp_pts_q;
  assign ts_overflow = ovf_q;
endmodule

// File: rtl/lts_coherence_mgr_chk.sv
module lts_coherence_mgr_chk #(
  parameter int NUM_CORES = 4,
  parameter int TS_W      = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_CORES-1:0]      req_valid,
  input logic [NUM_CORES-1:0]      req_ready,
  input logic                      rsp_valid,
  input logic [1:0]                rsp_op,
  input logic [TS_W-1:0]           rsp_wts,
  input logic [TS_W-1:0]           rsp_lease,
  input logic [TS_W-1:0]           rsp_pts,
  input logic [TS_W*NUM_CORES-1:0] core_pts,
  input logic                      ts_overflow
);
  p_ready_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  p_ready_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  p_rsp_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |=> rsp_valid);

  p_no_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req_valid & req_ready)) |=> !rsp_valid);

  p_read_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_op[1]) |-> (rsp_pts >= rsp_wts) && (rsp_lease >= rsp_pts));

  p_write_ts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_op == 2'b10) |-> (rsp_lease == rsp_pts) && (rsp_wts == rsp_pts));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ts_overflow |=> ts_overflow);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
    p_pts_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_pts[TS_W*c +: TS_W] >= $past(core_pts[TS_W*c +: TS_W]));

    p_pts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid[c] && req_ready[c]) |=> $stable(core_pts[TS_W*c +: TS_W]));
  end
endmodule

bind lts_coherence_mgr lts_coherence_mgr_chk #(
  .NUM_CORES (NUM_CORES),
  .TS_W      (TS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_op      (rsp_op),
  .rsp_wts     (rsp_wts),
  .rsp_lease   (rsp_lease),
  .rsp_pts     (rsp_pts),
  .core_pts    (core_pts),
  .ts_overflow (ts_overflow)
);

// File: tb/lts_coherence_mgr_test.sv
`timescale 1ns/1ps
module lts_coherence_mgr_test;
  localparam int NC = 4;
  localparam int NL = 8;
  localparam int DW = 16;
  localparam int TW = 8;
  localparam int LS = 40;
  localparam int CW = 2;
  localparam int LW = 3;
  localparam int TMAX = 255;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     req_valid = '0;
  logic [NC-1:0]     req_ready;
  logic [2*NC-1:0]   req_op = '0;
  logic [LW*NC-1:0]  req_line = '0;
  logic [DW*NC-1:0]  req_wdata = '0;
  logic              rsp_valid;
  logic [CW-1:0]     rsp_core;
  logic [1:0]        rsp_op;
  logic [DW-1:0]     rsp_data;
  logic [TW-1:0]     rsp_wts, rsp_lease, rsp_pts;
  logic [TW*NC-1:0]  core_pts;
  logic [TW*NC-1:0]  chk_lease = '0;
  logic [NC-1:0]     chk_ok;
  logic              ts_overflow;

  always #2 clk = ~clk;

  lts_coherence_mgr #(
    .NUM_CORES(NC), .NUM_LINES(NL), .DATA_W(DW), .TS_W(TW), .LEASE(LS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_line(req_line), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_op(rsp_op),
    .rsp_data(rsp_data), .rsp_wts(rsp_wts), .rsp_lease(rsp_lease),
    .rsp_pts(rsp_pts), .core_pts(core_pts), .chk_lease(chk_lease),
    .chk_ok(chk_ok), .ts_overflow(ts_overflow)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_pts [NC];
  int m_wts [NL];
  int m_rts [NL];
  int m_dat [NL];
  int m_own [NL];
  int m_rr;
  bit m_ovf;
  bit e_valid;
  int e_core, e_op, e_data, e_wts, e_lease, e_pts;

  task automatic model_reset();
    for (int i = 0; i < NC; i++) m_pts[i] = 0;
    for (int i = 0; i < NL; i++) begin
      m_wts[i] = 0; m_rts[i] = 0; m_dat[i] = 0; m_own[i] = -1;
    end
    m_rr = 0; m_ovf = 0; e_valid = 0;
  endtask

  task automatic model_cycle();
    int w, op, ln, wd, p, l;
    bit flush;
    logic [NC-1:0] exp_rdy;
    w = -1;
    for (int k = 0; k < NC; k++) begin
      int c;
      c = (m_rr + k) % NC;
      if (w < 0 && req_valid[c]) w = c;
    end
    op = 0; ln = 0; wd = 0; flush = 0; exp_rdy = '0;
    if (w >= 0) begin
      op = int'(req_op[w*2 +: 2]);
      ln = int'(req_line[w*LW +: LW]);
      wd = int'(req_wdata[w*DW +: DW]);
      flush = (m_own[ln] >= 0) && (m_own[ln] != w) && (op != 3);
      if (!flush) exp_rdy[w] = 1'b1;
    end
    // compare everything the block shows this cycle
    chk(req_ready == exp_rdy, "R8/R6 ready", req_ready, exp_rdy);
    chk(rsp_valid == e_valid, "R8 rsp_valid", rsp_valid, e_valid);
    if (e_valid) begin
      chk(int'(rsp_core) == e_core, "R8 rsp_core", rsp_core, e_core);
      chk(int'(rsp_data) == e_data, "R2/R3 rsp_data", rsp_data, e_data);
      chk(int'(rsp_wts) == e_wts, "R2/R3 rsp_wts", rsp_wts, e_wts);
      chk(int'(rsp_lease) == e_lease, "R2/R3 rsp_lease", rsp_lease, e_lease);
      chk(int'(rsp_pts) == e_pts, "R2/R3 rsp_pts", rsp_pts, e_pts);
    end
    for (int c = 0; c < NC; c++) begin
      chk(int'(core_pts[c*TW +: TW]) == m_pts[c], "R4 core clock", core_pts[c*TW +: TW], m_pts[c]);
      chk(chk_ok[c] == (m_pts[c] <= int'(chk_lease[c*TW +: TW])), "R5 chk_ok",
          chk_ok[c], m_pts[c] <= int'(chk_lease[c*TW +: TW]));
    end
    chk(ts_overflow == m_ovf, "R9 overflow flag", ts_overflow, m_ovf);
    // advance the model across the coming edge
    e_valid = 0;
    if (flush) begin
      m_own[ln] = -1;
    end else if (w >= 0) begin
      e_valid = 1; e_core = w; e_op = op;
      if (op == 0 || op == 1) begin
        p = (m_pts[w] > m_wts[ln]) ? m_pts[w] : m_wts[ln];
        l = ((m_rts[ln] > p) ? m_rts[ln] : p) + LS;
        if (l > TMAX) begin l = TMAX; m_ovf = 1; end
        e_data = m_dat[ln]; e_wts = m_wts[ln]; e_lease = l; e_pts = p;
        m_rts[ln] = l; m_pts[w] = p;
      end else if (op == 2) begin
        p = (m_pts[w] > m_rts[ln] + 1) ? m_pts[w] : m_rts[ln] + 1;
        if (p > TMAX) begin p = TMAX; m_ovf = 1; end
        m_wts[ln] = p; m_rts[ln] = p; m_dat[ln] = wd; m_own[ln] = w; m_pts[w] = p;
        e_data = wd; e_wts = p; e_lease = p; e_pts = p;
      end else begin
        if (m_own[ln] == w) m_own[ln] = -1;
        e_data = m_dat[ln]; e_wts = m_wts[ln]; e_lease = m_rts[ln]; e_pts = m_pts[w];
      end
      m_rr = (w + 1) % NC;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else if (!done) model_cycle();
  end

  // ---------------- directed stimulus ----------------
  int cap_stall, cap_data, cap_wts, cap_lease, cap_pts;

  task automatic issue(input int c, input int op, input int ln, input int wd);
    @(posedge clk); #1;
    req_op[c*2 +: 2]     = 2'(op);
    req_line[c*LW +: LW] = LW'(ln);
    req_wdata[c*DW +: DW] = DW'(wd);
    req_valid[c] = 1'b1;
    cap_stall = 0;
    forever begin
      @(negedge clk);
      if (req_ready[c]) break;
      cap_stall++;
    end
    @(posedge clk); #1;
    req_valid[c] = 1'b0;
    @(negedge clk);
    cap_data = int'(rsp_data); cap_wts = int'(rsp_wts);
    cap_lease = int'(rsp_lease); cap_pts = int'(rsp_pts);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(core_pts == '0, "R1 clocks zero", core_pts, 0);
    chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
    chk(ts_overflow == 1'b0, "R1 overflow clear", ts_overflow, 0);
    chk(chk_ok == 4'hF, "R1 chk_ok with zero lease", chk_ok, 15);

    // R2: first read of line 1 by core 0
    issue(0, 0, 1, 0);
    chk(cap_lease == 40, "R2 lease granted", cap_lease, 40);
    chk(cap_pts == 0, "R2 reader clock", cap_pts, 0);

    // R3: write by core 1 jumps past the lease
    issue(1, 2, 1, 16'hBEEF);
    chk(cap_pts == 41, "R3 writer clock", cap_pts, 41);
    chk(cap_lease == 41, "R3 new lease", cap_lease, 41);

    // R4/R5: the old reader keeps its lease, no invalidation
    @(posedge clk); #1;
    chk_lease[0*TW +: TW] = 8'd40;
    chk_lease[1*TW +: TW] = 8'd10;
    @(negedge clk);
    chk(int'(core_pts[0 +: TW]) == 0, "R4 other clock untouched", core_pts[0 +: TW], 0);
    chk(chk_ok[0] == 1'b1, "R5 old copy still valid", chk_ok[0], 1);
    chk(chk_ok[1] == 1'b0, "R5 expired lease", chk_ok[1], 0);

    // R6: read of owned line stalls exactly one cycle
    issue(2, 0, 1, 0);
    chk(cap_stall == 1, "R6 flush stall", cap_stall, 1);
    chk(cap_data == 16'hBEEF, "R6 flushed data", cap_data, 16'hBEEF);
    chk(cap_lease == 81, "R6 lease after flush", cap_lease, 81);

    // R7: writeback by owner releases without stall for others
    issue(1, 2, 2, 16'h1234);
    issue(1, 3, 2, 0);
    chk(cap_stall == 0, "R7 owner writeback", cap_stall, 0);
    chk(cap_wts == 41, "R7 writeback keeps wts", cap_wts, 41);
    issue(3, 0, 2, 0);
    chk(cap_stall == 0, "R7 no flush after writeback", cap_stall, 0);
    chk(cap_data == 16'h1234, "R7 data visible", cap_data, 16'h1234);
    issue(0, 3, 2, 0);
    chk(cap_lease == 81, "R7 non-owner writeback no effect", cap_lease, 81);

    // R10: renewal follows the read rules
    issue(0, 1, 1, 0);
    chk(cap_pts == 41, "R10 renew clock", cap_pts, 41);
    chk(cap_lease == 121, "R10 renew lease", cap_lease, 121);

    // R8: all cores at once; pointer sits at core 1
    begin
      int order [4];
      int n;
      n = 0;
      @(posedge clk); #1;
      for (int c = 0; c < NC; c++) begin
        req_op[c*2 +: 2] = 2'b00;
        req_line[c*LW +: LW] = LW'(4 + c);
      end
      req_valid = 4'hF;
      for (int cyc = 0; cyc < 8 && req_valid != '0; cyc++) begin
        logic [NC-1:0] g;
        @(negedge clk);
        g = req_ready;
        for (int c = 0; c < NC; c++) if (g[c] && n < 4) begin order[n] = c; n++; end
        @(posedge clk); #1;
        req_valid = req_valid & ~g;
      end
      chk(n == 4, "R8 four grants", n, 4);
      for (int i = 0; i < 4; i++)
        chk(order[i] == (1 + i) % NC, "R8 rotation order", order[i], (1 + i) % NC);
    end

    // R9: alternate writes and reads until the clock saturates
    for (int i = 0; i < 10; i++) begin
      issue(0, 2, 3, i);
      if (ts_overflow) break;
      issue(0, 0, 3, 0);
      if (ts_overflow) break;
    end
    chk(ts_overflow == 1'b1, "R9 overflow raised", ts_overflow, 1);
    chk(cap_lease == TMAX, "R9 lease saturates", cap_lease, TMAX);
    issue(0, 2, 3, 7);
    chk(cap_pts == TMAX, "R9 clock saturates", cap_pts, TMAX);
    issue(2, 0, 5, 0);
    chk(ts_overflow == 1'b1, "R9 overflow sticky", ts_overflow, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule